// File: doc/BRIEF.md
# Keyed Independent Watchdog

This block is a watchdog timer that runs from its own slow clock of roughly 32 kHz and needs no other clock to keep counting. Software drives it through three registers on a small write port: a key register, a prescaler select and a reload value. Every control action is a write of a specific 16-bit magic value to the key register. One value opens the prescaler and reload registers for writing. One starts the countdown. One refreshes the countdown from the reload value.

Once started, the watchdog cannot be stopped by any write; only the system reset clears it. The slow clock is first divided by a power of two chosen by the prescaler code, which gives a tick. A down-counter is decremented on each tick. When the count runs out, the block raises a one-cycle reset request for the rest of the system. The timeout is therefore the reload value times the prescale divide ratio, counted in slow-clock cycles. For example, a reload of 500 at a divide ratio of 256 from 32 kHz gives 4 seconds.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the watchdog is stopped, `reset_req` is low, the configuration is locked, the prescaler code is 0 and the reload value is 0xFFF.
- R2: Writing 0x5555 to offset 0 (key) unlocks the configuration. While unlocked, a write to offset 1 sets the prescaler code from data bits [2:0], and a write to offset 2 sets the reload value from data bits [11:0].
- R3: Prescaler and reload writes made while the configuration is locked leave both registers unchanged.
- R4: Writing 0xCCCC to the key register starts a stopped watchdog. This loads the counter from the reload value and clears the prescale divider, so the first `reset_req` goes high in the cycle that follows reload × ratio clock edges after the start write.
- R5: A running watchdog keeps running and keeps issuing requests whatever is written afterwards. A further 0xCCCC write while running leaves the countdown untouched.
- R6: Writing 0xAAAA to the key register reloads the counter from the reload value, clears the prescale divider and re-locks the configuration.
- R7: Writing any key value other than 0x5555, 0xCCCC or 0xAAAA re-locks the configuration.
- R8: Prescaler code c in 0..6 selects a divide ratio of 4·2^c (4 to 256). Codes 7 and above behave as code 6.
- R9: The counter decrements once per tick. `reset_req` is a pulse exactly one clock cycle wide, issued on the tick that takes the count to zero.
- R10: After issuing a request, a running watchdog reloads its counter from the current reload value and continues. The next request follows reload × ratio cycles later.
- R11: A reload value of 0 behaves as a timeout of one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow independent oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register offset: 0 key, 1 prescaler, 2 reload, 3 unused |
| wr_data | input | 16 | Write data |
| reset_req | output | 1 | One-cycle system reset request on timeout |

## Verification
The bench builds the block with its default parameters: a 12-bit reload register, a base divide ratio of 4 and prescaler codes up to 6 in a 3-bit field. With these values, the reset-default timeout of 4095 ticks at divide-by-4 (16380 cycles) can be reached and timed exactly. So can the largest ratio of 256 combined with small reload values, and the clamp of code 7 onto the largest ratio. Each scenario counts clock edges from the start or refresh write and compares the edge on which the request appears against reload × ratio.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int KEY_W = 16;

  localparam logic [KEY_W-1:0] KEY_OPEN    = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_RUN     = 16'hCCCC;
  localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;

  typedef enum logic [1:0] {
    SEL_KEY    = 2'd0,
    SEL_PRE    = 2'd1,
    SEL_RELOAD = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/kwd_keyctl.sv
module kwd_keyctl
  import kwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [KEY_W-1:0] wr_data,
  output logic             unlocked_q,
  output logic             running_q,
  output logic             start_load,
  output logic             refresh_load
);
  logic key_wr, k_open, k_run, k_refresh, k_other;

  always_comb begin
    key_wr    = wr_en && (wr_addr == SEL_KEY);
    k_open    = key_wr && (wr_data == KEY_OPEN);
    k_run     = key_wr && (wr_data == KEY_RUN);
    k_refresh = key_wr && (wr_data == KEY_REFRESH);
    k_other   = key_wr && !k_open && !k_run && !k_refresh;
  end

  // a start only loads the counter the first time; later starts are inert
  assign start_load   = k_run && !running_q;
  assign refresh_load = k_refresh;

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked_q <= 1'b0;
      running_q  <= 1'b0;
    end else begin
      if (k_open)
        unlocked_q <= 1'b1;
      else if (k_refresh || k_other)
        unlocked_q <= 1'b0;
      if (k_run)
        running_q <= 1'b1;
    end
  end
endmodule

// File: rtl/kwd_cfg_regs.sv
module kwd_cfg_regs
  import kwd_pkg::*;
#(
  parameter int PRE_W    = 3,
  parameter int RELOAD_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic                unlocked,
  input  logic [PRE_W-1:0]    pre_din,
  input  logic [RELOAD_W-1:0] reload_din,
  output logic [PRE_W-1:0]    pre_q,
  output logic [RELOAD_W-1:0] reload_q
);
  localparam logic [RELOAD_W-1:0] RELOAD_RST = {RELOAD_W{1'b1}};

  logic pre_we, reload_we;

  assign pre_we    = wr_en && unlocked && (wr_addr == SEL_PRE);
  assign reload_we = wr_en && unlocked && (wr_addr == SEL_RELOAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q    <= '0;
      reload_q <= RELOAD_RST;
    end else begin
      if (pre_we)    pre_q    <= pre_din;
      if (reload_we) reload_q <= reload_din;
    end
  end
endmodule

// File: rtl/kwd_prescaler.sv
module kwd_prescaler #(
  parameter int PRE_W         = 3,
  parameter int PRE_BASE_LOG2 = 2,
  parameter int MAX_CODE      = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             clr,
  input  logic [PRE_W-1:0] code,
  output logic             tick
);
  localparam int DIV_W = PRE_BASE_LOG2 + MAX_CODE;

  logic [DIV_W-1:0] lim_tab [0:MAX_CODE];
  logic [PRE_W-1:0] code_eff;
  logic [DIV_W-1:0] lim;
  logic [DIV_W-1:0] div_q;

  // terminal count for each selectable ratio
  for (genvar g = 0; g <= MAX_CODE; g++) begin : g_lim
    assign lim_tab[g] = DIV_W'((1 << (PRE_BASE_LOG2 + g)) - 1);
  end

  assign code_eff = (code > PRE_W'(MAX_CODE)) ? PRE_W'(MAX_CODE) : code;
  assign lim      = lim_tab[code_eff];
  // >= keeps a mid-count ratio change from wrapping the divider
  assign tick     = en && !clr && (div_q >= lim);

  always_ff @(posedge clk) begin
    if (rst || clr || !en || tick)
      div_q <= '0;
    else
      div_q <= div_q + DIV_W'(1);
  end
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
  parameter int RELOAD_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                tick,
  input  logic [RELOAD_W-1:0] reload,
  output logic [RELOAD_W-1:0] cnt_q,
  output logic                fire_q
);
  localparam logic [RELOAD_W-1:0] CNT_RST = {RELOAD_W{1'b1}};

  logic expire;

  // the tick that would take the count to zero ends the period
  assign expire = tick && !load && (cnt_q <= RELOAD_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= CNT_RST;
      fire_q <= 1'b0;
    end else begin
      fire_q <= expire;
      if (load || expire)
        cnt_q <= reload;
      else if (tick)
        cnt_q <= cnt_q - RELOAD_W'(1);
    end
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int RELOAD_W      = 12,
  parameter int PRE_W         = 3,
  parameter int PRE_BASE_LOG2 = 2,
  parameter int MAX_CODE      = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [KEY_W-1:0] wr_data,
  output logic             reset_req
);
  logic                unlocked_q, running_q;
  logic                start_load, refresh_load, cnt_load;
  logic [PRE_W-1:0]    pre_q;
  logic [RELOAD_W-1:0] reload_q;
  logic [RELOAD_W-1:0] cnt_q;
  logic                tick;

  assign cnt_load = start_load | refresh_load;

  kwd_keyctl u_key (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .unlocked_q   (unlocked_q),
    .running_q    (running_q),
    .start_load   (start_load),
    .refresh_load (refresh_load)
  );

  kwd_cfg_regs #(.PRE_W(PRE_W), .RELOAD_W(RELOAD_W)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .unlocked   (unlocked_q),
    .pre_din    (wr_data[PRE_W-1:0]),
    .reload_din (wr_data[RELOAD_W-1:0]),
    .pre_q      (pre_q),
    .reload_q   (reload_q)
  );

  kwd_prescaler #(
    .PRE_W(PRE_W), .PRE_BASE_LOG2(PRE_BASE_LOG2), .MAX_CODE(MAX_CODE)
  ) u_pre (
    .clk  (clk),
    .rst  (rst),
    .en   (running_q),
    .clr  (cnt_load),
    .code (pre_q),
    .tick (tick)
  );

  kwd_counter #(.RELOAD_W(RELOAD_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .load   (cnt_load),
    .tick   (tick),
    .reload (reload_q),
    .cnt_q  (cnt_q),
    .fire_q (reset_req)
  );
endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk
  import kwd_pkg::*;
#(
  parameter int RELOAD_W = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic [1:0]          wr_addr,
  input logic [KEY_W-1:0]    wr_data,
  input logic                reset_req,
  input logic                unlocked,
  input logic                running,
  input logic [RELOAD_W-1:0] reload_q,
  input logic [RELOAD_W-1:0] cnt_q,
  input logic                tick,
  input logic                cnt_load
);
  assert_open_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd0 && wr_data == KEY_OPEN) |=> unlocked);

  assert_locked_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd2 && !unlocked) |=> $stable(reload_q));

  assert_req_when_running_R4: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> running);

  assert_no_stop_R5: assert property (@(posedge clk) disable iff (rst)
    running |=> running);

  assert_refresh_relock_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd0 && wr_data == KEY_REFRESH) |=> !unlocked);

  assert_pulse_width_R9: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> !reset_req);

  assert_fire_R9: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_load && cnt_q <= RELOAD_W'(1)) |=> reset_req);

  assert_decrement_R9: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_load && cnt_q > RELOAD_W'(1)) |=> (cnt_q == $past(cnt_q) - RELOAD_W'(1)));
endmodule

bind keyed_watchdog keyed_watchdog_chk #(.RELOAD_W(RELOAD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .reset_req (reset_req),
  .unlocked  (unlocked_q),
  .running   (running_q),
  .reload_q  (reload_q),
  .cnt_q     (cnt_q),
  .tick      (tick),
  .cnt_load  (cnt_load)
);

// File: tb/sim_keyed_watchdog.sv
`timescale 1ns/1ps
module sim_keyed_watchdog;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        reset_req;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  keyed_watchdog u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .reset_req(reset_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // returns at the negedge following the capturing clock edge
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // cycle stamp of the next observed request, or -1
  task automatic wait_req(input int limit, output int stamp);
    stamp = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (reset_req) begin
        stamp = cyc;
        break;
      end
    end
  endtask

  task automatic setup(input int code, input int rld);
    wr(2'd0, 16'h5555);
    wr(2'd1, 16'(code));
    wr(2'd2, 16'(rld));
  endtask

  task automatic t_reset_idle();
    int seen = 0;
    do_reset();
    chk("R1 req low in reset", int'(reset_req), 0);
    repeat (60) @(negedge clk) if (reset_req) seen++;
    chk("R1 stopped after reset", seen, 0);
  endtask

  task automatic t_locked_default();
    int t0, p;
    do_reset();
    wr(2'd2, 16'd3);      // locked: ignored
    wr(2'd1, 16'd2);      // locked: ignored
    wr(2'd0, 16'hCCCC);
    t0 = cyc;
    wait_req(20000, p);
    chk("R1/R3 default reload and code, locked writes ignored", p - t0, 4095 * 4);
  endtask

  task automatic t_ratio(input int code, input int rld, input int ratio, input string req);
    int t0, p;
    do_reset();
    setup(code, rld);
    wr(2'd0, 16'hCCCC);
    t0 = cyc;
    wait_req(4000, p);
    chk(req, p - t0, rld * ratio);
  endtask

  task automatic t_relock_other();
    int t0, p;
    do_reset();
    setup(0, 8);
    wr(2'd0, 16'h1234);   // R7 relock
    wr(2'd2, 16'd2);
    wr(2'd1, 16'd5);
    wr(2'd0, 16'hCCCC);
    t0 = cyc;
    wait_req(2000, p);
    chk("R7 unknown key relocks", p - t0, 32);
  endtask

  task automatic t_relock_refresh();
    int t0, p;
    do_reset();
    setup(0, 6);
    wr(2'd0, 16'hAAAA);   // R6 relock
    wr(2'd2, 16'd1);
    wr(2'd0, 16'hCCCC);
    t0 = cyc;
    wait_req(2000, p);
    chk("R6 refresh key relocks", p - t0, 24);
  endtask

  task automatic t_refresh_postpones();
    int t1, p, early = 0;
    do_reset();
    setup(0, 10);
    wr(2'd0, 16'hCCCC);
    repeat (25) @(negedge clk) if (reset_req) early++;
    wr(2'd0, 16'hAAAA);
    t1 = cyc;
    chk("R6 no request before refresh", early, 0);
    wait_req(2000, p);
    chk("R6 refresh restarts countdown", p - t1, 40);
  endtask

  task automatic t_no_stop();
    int t0, p, p2;
    do_reset();
    setup(0, 10);
    wr(2'd0, 16'hCCCC);
    t0 = cyc;
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'hFFFF);
    wr(2'd0, 16'hCCCC);   // repeated start: countdown untouched
    wr(2'd0, 16'h5555);
    wr(2'd2, 16'd2);
    wait_req(2000, p);
    chk("R5 still running after writes", p - t0, 40);
    wait_req(2000, p2);
    chk("R5 keeps running with new reload", p2 - p, 8);
  endtask

  task automatic t_periodic();
    int t0, p, p2;
    do_reset();
    setup(1, 5);
    wr(2'd0, 16'hCCCC);
    t0 = cyc;
    wait_req(2000, p);
    chk("R9 first request", p - t0, 40);
    @(negedge clk);
    chk("R9 request one cycle wide", int'(reset_req), 0);
    wait_req(2000, p2);
    chk("R10 auto reload period", p2 - p, 40);
  endtask

  task automatic t_zero_reload();
    int t0, p, p2;
    do_reset();
    setup(0, 0);
    wr(2'd0, 16'hCCCC);
    t0 = cyc;
    wait_req(200, p);
    chk("R11 reload 0 acts as one tick", p - t0, 4);
    wait_req(200, p2);
    chk("R11 reload 0 repeat", p2 - p, 4);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    t_reset_idle();
    t_locked_default();
    t_ratio(3, 5, 32, "R2/R8 code 3 ratio 32");
    t_ratio(6, 4, 256, "R8 code 6 ratio 256");
    t_ratio(7, 3, 256, "R8 code 7 clamps to 256");
    t_ratio(0, 7, 4, "R4 start from code 0");
    t_relock_other();
    t_relock_refresh();
    t_refresh_postpones();
    t_no_stop();
    t_periodic();
    t_zero_reload();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule